// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt request lines into a register of pending requests. Each line is captured either on a rising edge or by level, as chosen at run time by a trigger-mode register. A mask vector hides lines from the unmasked output, but their pending bits are still recorded. A per-line acknowledge strobe from a later arbitration stage clears pending bits for edge-captured lines. Priority resolution, in-service tracking and vector generation are left to other blocks.

Every line first passes through a two-flop synchroniser. A small per-line state machine then holds two bits: whether the line is pending, and the level seen on the previous sample. The four states are `LN_QUIET` (not pending, previous low), `LN_HELD` (not pending, previous high), `LN_PEND_LO` (pending, previous low) and `LN_PEND_HI` (pending, previous high). On each clock the next state is chosen from the synchronised sample, the line's mode, its acknowledge and the init strobe. In level mode the pending bit takes the sample. In edge mode the pending bit is set by a sample that is high while the previous level was low, and otherwise it is kept unless acknowledged. Every transition loads the previous-level bit with the sample, except that an init strobe forces it low. The trigger-mode register is written through a byte port, and a fixed per-instance write mask holds selected lines edge-only. The default mask is 0xF8. A second controller uses 0xDE.

Top module: `irq_req_latch`

## Requirements
- R1: While reset is asserted, and after it is released, `pend`, `pend_unmasked` and `trig_mode` are all zero.
- R2: For a line whose `trig_mode` bit is 1 (level), the pending bit equals the request line as sampled three rising edges earlier. A change on `req_in` shows on `pend` after the third rising edge.
- R3: For a line whose `trig_mode` bit is 0 (edge), the pending bit is set when the synchronised sample is high and the remembered previous level is low.
- R4: In edge mode a low sample does not clear the pending bit. A line that stays high does not set the bit again after it has been acknowledged.
- R5: An `ack_clr` bit clears the pending bit of an edge-mode line on the next edge. For a level-mode line it has no effect.
- R6: If an edge-mode line sees a new rising sample in the same cycle as its `ack_clr`, the pending bit stays set.
- R7: A masked line (`mask` bit 1) still records its pending bit. `pend_unmasked` is `pend` with masked lines forced to 0, in the same cycle.
- R8: A `trig_wr_en` cycle loads `trig_wr_data & TRIG_WR_MASK` into `trig_mode` on the next edge. Bits that are 0 in the mask (lines 0, 1 and 2 by default) always read 0.
- R9: An `init_clr` cycle clears every remembered previous level, so an edge-mode line that is still high becomes pending again on the following edge.
- R10: The remembered previous level is updated in both modes. A line switched from level to edge while it is high does not become pending again after being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | LINES | Raw request lines, asynchronous |
| mask | input | LINES | 1 hides the line from `pend_unmasked` |
| ack_clr | input | LINES | Per-line acknowledge clear strobe |
| init_clr | input | 1 | Initialization strobe: clears previous levels |
| trig_wr_en | input | 1 | Trigger-mode write enable |
| trig_wr_data | input | LINES | Trigger-mode write data, 1 = level |
| pend | output | LINES | Pending request vector |
| pend_unmasked | output | LINES | Pending and not masked |
| trig_mode | output | LINES | Stored trigger-mode register |

## Verification
Directed patterns cover several cases. A one-cycle pulse on an edge line tells edge capture apart from level following, because the bit must outlast the pulse. A line held high through an acknowledge separates correct previous-level tracking from a design that sets the bit again on every high sample. Init and a switch from level to edge while the line is high each confirm that the previous level is cleared by init and is otherwise kept. A set that arrives in the same cycle as an acknowledge exposes the wrong priority. A long run of random request, mask, acknowledge, mode and init traffic is compared every cycle with a behavioural model. This catches interactions the directed cases miss.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    // bit 1 = pending, bit 0 = previous sampled level
    typedef enum logic [1:0] {
        LN_QUIET   = 2'b00,
        LN_HELD    = 2'b01,
        LN_PEND_LO = 2'b10,
        LN_PEND_HI = 2'b11
    } line_state_t;

    function automatic line_state_t pack_state(input logic pend_b, input logic prev_b);
        line_state_t st;
        unique case ({pend_b, prev_b})
            2'b00:   st = LN_QUIET;
            2'b01:   st = LN_HELD;
            2'b10:   st = LN_PEND_LO;
            default: st = LN_PEND_HI;
        endcase
        return st;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0][WIDTH-1:0] stage;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = stage[LAST];
endmodule

// File: rtl/irq_trig_reg.sv
module irq_trig_reg #(
    parameter int               WIDTH   = 8,
    parameter logic [WIDTH-1:0] WR_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] mode_q
);
    logic [WIDTH-1:0] mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) mode_d = wr_data & WR_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import irq_latch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic samp,
    input  logic level_mode,
    input  logic ack,
    input  logic init,
    output logic pend,
    output logic prev
);
    line_state_t state_q, state_d;
    logic        pend_n, prev_n;

    // next-state process
    always_comb begin
        pend_n = 1'b0;
        unique case (state_q)
            LN_QUIET: begin
                // previous low: a high sample captures in either mode
                pend_n = samp;
            end
            LN_HELD: begin
                // previous high: only level mode can raise pending
                pend_n = level_mode ? samp : 1'b0;
            end
            LN_PEND_LO: begin
                pend_n = level_mode ? samp : (samp | ~ack);
            end
            LN_PEND_HI: begin
                pend_n = level_mode ? samp : ~ack;
            end
        endcase
        prev_n  = init ? 1'b0 : samp;
        state_d = pack_state(pend_n, prev_n);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_QUIET;
        else        state_q <= state_d;
    end

    // output process
    always_comb begin
        pend = 1'b0;
        prev = 1'b0;
        unique case (state_q)
            LN_QUIET:   begin pend = 1'b0; prev = 1'b0; end
            LN_HELD:    begin pend = 1'b0; prev = 1'b1; end
            LN_PEND_LO: begin pend = 1'b1; prev = 1'b0; end
            LN_PEND_HI: begin pend = 1'b1; prev = 1'b1; end
        endcase
    end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int               LINES        = 8,
    parameter int               SYNC_DEPTH   = 2,
    parameter logic [LINES-1:0] TRIG_WR_MASK = 8'hF8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] req_in,
    input  logic [LINES-1:0] mask,
    input  logic [LINES-1:0] ack_clr,
    input  logic             init_clr,
    input  logic             trig_wr_en,
    input  logic [LINES-1:0] trig_wr_data,
    output logic [LINES-1:0] pend,
    output logic [LINES-1:0] pend_unmasked,
    output logic [LINES-1:0] trig_mode
);
    logic [LINES-1:0] line_samp;
    logic [LINES-1:0] line_prev;

    irq_sync #(.WIDTH(LINES), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (req_in),
        .q_sync  (line_samp)
    );

    irq_trig_reg #(.WIDTH(LINES), .WR_MASK(TRIG_WR_MASK)) u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (trig_wr_en),
        .wr_data (trig_wr_data),
        .mode_q  (trig_mode)
    );

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_line
            irq_line_fsm u_fsm (
                .clk        (clk),
                .rst_n      (rst_n),
                .samp       (line_samp[i]),
                .level_mode (trig_mode[i]),
                .ack        (ack_clr[i]),
                .init       (init_clr),
                .pend       (pend[i]),
                .prev       (line_prev[i])
            );
        end
    endgenerate

    assign pend_unmasked = pend & ~mask;
endmodule

// File: rtl/irq_req_latch_chk.sv
module irq_req_latch_chk #(
    parameter int               LINES        = 8,
    parameter logic [LINES-1:0] TRIG_WR_MASK = 8'hF8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] mask,
    input logic [LINES-1:0] ack_clr,
    input logic             trig_wr_en,
    input logic [LINES-1:0] trig_wr_data,
    input logic [LINES-1:0] pend,
    input logic [LINES-1:0] pend_unmasked,
    input logic [LINES-1:0] trig_mode,
    input logic [LINES-1:0] samp
);
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && trig_mode == '0));

    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_unmasked & mask) == '0) && ((pend_unmasked & ~pend) == '0));

    p_trig_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_mode & ~TRIG_WR_MASK) == '0);

    p_trig_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_en |=> trig_mode == ($past(trig_wr_data) & TRIG_WR_MASK));

    genvar i;
    generate
        for (i = 0; i < LINES; i++) begin : g_ln
            p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
                trig_mode[i] |=> pend[i] == $past(samp[i]));

            p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (!trig_mode[i] && pend[i] && !ack_clr[i]) |=> pend[i]);

            p_edge_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (!trig_mode[i] && ack_clr[i] && !samp[i]) |=> !pend[i]);
        end
    endgenerate
endmodule

bind irq_req_latch irq_req_latch_chk #(
    .LINES        (LINES),
    .TRIG_WR_MASK (TRIG_WR_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mask          (mask),
    .ack_clr       (ack_clr),
    .trig_wr_en    (trig_wr_en),
    .trig_wr_data  (trig_wr_data),
    .pend          (pend),
    .pend_unmasked (pend_unmasked),
    .trig_mode     (trig_mode),
    .samp          (line_samp)
);

// File: tb/tb_irq_req_latch.sv
module tb_irq_req_latch;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req_in = '0, mask = '0, ack_clr = '0, trig_wr_data = '0;
    logic         init_clr = 1'b0, trig_wr_en = 1'b0;
    logic [N-1:0] pend, pend_unmasked, trig_mode;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_req_latch dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .mask(mask),
        .ack_clr(ack_clr), .init_clr(init_clr), .trig_wr_en(trig_wr_en),
        .trig_wr_data(trig_wr_data), .pend(pend), .pend_unmasked(pend_unmasked),
        .trig_mode(trig_mode)
    );

    // behavioural reference: a delay queue for the synchroniser plus per-line bits
    logic [N-1:0] dq[$];
    logic [N-1:0] m_pend = '0, m_prev = '0, m_trig = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq = '{'0, '0};
            m_pend = '0; m_prev = '0; m_trig = '0;
        end else begin
            logic [N-1:0] s, np;
            s = dq.pop_front();
            dq.push_back(req_in);
            for (int k = 0; k < N; k++) begin
                if (m_trig[k]) np[k] = s[k];
                else np[k] = (s[k] && !m_prev[k]) || (m_pend[k] && !ack_clr[k]);
            end
            m_pend = np;
            m_prev = init_clr ? '0 : s;
            if (trig_wr_en) m_trig = trig_wr_data & 8'hF8;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // advance one cycle, compare the model at the falling edge
    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("MODEL R2 R3 R4 R5 R6 R9 R10 pend", pend, m_pend);
            chk("MODEL R7 unmasked", pend_unmasked, m_pend & ~mask);
            chk("MODEL R8 trig", trig_mode, m_trig);
        end
    endtask

    task automatic wr_trig(input logic [N-1:0] v);
        trig_wr_en = 1'b1; trig_wr_data = v;
        tick();
        trig_wr_en = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        chk("R1 pend in reset", pend, '0);
        chk("R1 trig in reset", trig_mode, '0);
        rst_n = 1'b1;
        tick();
        chk("R1 pend after reset", pend, '0);
        chk("R1 unmasked after reset", pend_unmasked, '0);

        // R8: reserved lines forced to edge
        wr_trig(8'hFF);
        chk("R8 write FF", trig_mode, 8'hF8);
        wr_trig(8'h07);
        chk("R8 write 07", trig_mode, 8'h00);

        wr_trig(8'hF0); // lines 4..7 level, 0..3 edge

        // R2: level line follows after three edges
        req_in[4] = 1'b1;
        tick(2);
        chk("R2 level not yet", {7'b0, pend[4]}, 8'h00);
        tick();
        chk("R2 level set", {7'b0, pend[4]}, 8'h01);
        req_in[4] = 1'b0;
        tick(3);
        chk("R2 level cleared", {7'b0, pend[4]}, 8'h00);

        // R3/R4: one-cycle pulse on edge line 0 is held
        req_in[0] = 1'b1;
        tick();
        req_in[0] = 1'b0;
        tick(5);
        chk("R3 R4 edge pulse held", {7'b0, pend[0]}, 8'h01);

        // R7: masked line keeps pending but is hidden
        mask = 8'h01;
        tick();
        chk("R7 masked pend", {7'b0, pend[0]}, 8'h01);
        chk("R7 masked hidden", {7'b0, pend_unmasked[0]}, 8'h00);
        mask = 8'h00;
        tick();
        chk("R7 unmasked shown", {7'b0, pend_unmasked[0]}, 8'h01);

        // R5: ack clears edge line
        ack_clr[0] = 1'b1;
        tick();
        ack_clr[0] = 1'b0;
        chk("R5 edge ack", {7'b0, pend[0]}, 8'h00);

        // R4/R9: edge line 1 held high, acked, not re-set; init re-arms it
        req_in[1] = 1'b1;
        tick(3);
        chk("R3 edge held set", {7'b0, pend[1]}, 8'h01);
        ack_clr[1] = 1'b1;
        tick();
        ack_clr[1] = 1'b0;
        tick(3);
        chk("R4 high after ack no reset", {7'b0, pend[1]}, 8'h00);
        init_clr = 1'b1;
        tick();
        init_clr = 1'b0;
        chk("R9 init cycle", {7'b0, pend[1]}, 8'h00);
        tick();
        chk("R9 re-armed after init", {7'b0, pend[1]}, 8'h01);
        req_in[1] = 1'b0;
        ack_clr[1] = 1'b1;
        tick();
        ack_clr[1] = 1'b0;

        // R5: ack ignored on level line 5
        req_in[5] = 1'b1;
        tick(3);
        ack_clr[5] = 1'b1;
        tick();
        ack_clr[5] = 1'b0;
        chk("R5 level ignores ack", {7'b0, pend[5]}, 8'h01);
        req_in[5] = 1'b0;
        tick(3);

        // R6: new rising sample and ack in the same cycle on edge line 2
        req_in[2] = 1'b1;
        tick();
        req_in[2] = 1'b0;
        tick(4);
        req_in[2] = 1'b1;
        tick(2);
        ack_clr[2] = 1'b1;
        tick();
        ack_clr[2] = 1'b0;
        chk("R6 set beats ack", {7'b0, pend[2]}, 8'h01);
        req_in[2] = 1'b0;
        ack_clr[2] = 1'b1;
        tick();
        ack_clr[2] = 1'b0;

        // R10: level line 6 high, switched to edge, acked: no new capture
        req_in[6] = 1'b1;
        tick(3);
        chk("R10 level high", {7'b0, pend[6]}, 8'h01);
        wr_trig(8'hB0);
        ack_clr[6] = 1'b1;
        tick();
        ack_clr[6] = 1'b0;
        tick(3);
        chk("R10 no edge after switch", {7'b0, pend[6]}, 8'h00);
        req_in[6] = 1'b0;
        tick(3);

        // random traffic against the model
        for (int c = 0; c < 2000; c++) begin
            req_in = N'($urandom);
            mask = N'($urandom);
            ack_clr = N'($urandom) & N'($urandom);
            init_clr = ($urandom % 16) == 0;
            trig_wr_en = ($urandom % 20) == 0;
            trig_wr_data = N'($urandom);
            tick();
        end
        req_in = '0; ack_clr = '0; init_clr = 1'b0; trig_wr_en = 1'b0;
        tick(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule